// File: doc/BRIEF.md
# Miss-ranked victim and stream buffer

This block is a small fully associative store placed between the private first-level caches of four cores and their shared second-level cache. It has three parts. A miss table counts how often each block address has missed in a first-level cache. A victim region keeps blocks that a first-level cache throws out. A stream region keeps the extra blocks that arrive with a miss fill. Every port carries a block address, which is a 32-bit byte address with the 7 offset bits of a 128-byte block removed. Each stored block carries one data word.

A first-level miss is presented on the lookup port. The victim and stream regions are searched at once, and the answer comes back one cycle later. A hit hands the block back and frees its slot, because the block now lives in the first-level cache again. Evicted blocks are offered on the insert port. They are ranked against the miss counts of the blocks already held, so a rarely missed block cannot push out a frequently missed one. Prefetched neighbours come in on the fill port. An enable input switches the whole unit off. All four cores share one set of contents.

Top module: `victim_stream_buf`

## Requirements
- R1: After reset every region and the miss table are empty, rsp_valid and wb_valid are 0, and the first lookup misses.
- R2: A lookup presented in cycle N gives rsp_valid=1 in cycle N+1, with rsp_core equal to the core ID sent with it. rsp_hit, rsp_data and rsp_dirty report the result.
- R3: A lookup whose block address is held in the victim region hits. It returns that block's data word and dirty flag and frees the slot, so a second lookup of the same address misses.
- R4: The stream region holds 3 blocks. A fill into a full stream region replaces the block that was filled earliest, and a stream hit returns the data with rsp_dirty=0 and frees the slot.
- R5: Each enabled lookup counts one miss for its block address, saturating at 15. An address with no entry gets a new entry with count 1. When the table (16 entries per table block) is full, the entry used least recently is replaced, and its count is forgotten (it reads as 0).
- R6: An evicted block is taken into the victim region when a slot is free. When the region is full, it is taken only if its current miss count is at least the lowest count recorded with the blocks already held. Otherwise it is dropped, and a later lookup of it misses.
- R7: A block taken into a full victim region replaces the least recently inserted victim. If that victim is dirty, wb_valid pulses for one cycle, in the cycle after the insert, with wb_tag and wb_data of the displaced block. A clean victim leaves without a pulse.
- R8: While en=0, every lookup answers with rsp_hit=0, inserts and fills are ignored, and miss counts do not change. Contents held before are still there when en returns to 1.
- R9: An eviction or fill whose block address equals that of a same-cycle enabled lookup is ignored. The lookup result is unaffected.
- R10: The core ID does not affect storage: a block inserted in one place is hit by a lookup from any core.
- R11: Inserting a block already held in the victim region overwrites its data word in place, ORs in the dirty flag and takes no new slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Unit enable; 0 makes lookups miss and drops inserts |
| lk_valid | input | 1 | Lookup request (a first-level miss) |
| lk_core | input | 2 | Requesting core |
| lk_tag | input | 25 | Block address looked up |
| ev_valid | input | 1 | Evicted block offered |
| ev_tag | input | 25 | Block address of the evicted block |
| ev_data | input | DATA_W | Data word of the evicted block |
| ev_dirty | input | 1 | Evicted block is modified |
| pf_valid | input | 1 | Prefetched neighbour offered |
| pf_tag | input | 25 | Block address of the prefetched block |
| pf_data | input | DATA_W | Data word of the prefetched block |
| rsp_valid | output | 1 | Lookup answer, one cycle after the lookup |
| rsp_core | output | 2 | Core of the answered lookup |
| rsp_hit | output | 1 | The block was found |
| rsp_dirty | output | 1 | Returned block is modified |
| rsp_data | output | DATA_W | Returned data word |
| wb_valid | output | 1 | One-cycle write-back of a displaced dirty victim |
| wb_tag | output | 25 | Block address to write back |
| wb_data | output | DATA_W | Data word to write back |

## Verification
The assertions assume that no block address is held in both the victim and the stream region at once. The bench keeps to this by never filling an address into one region while the other holds it. They also assume that the use stamp does not wrap. The run is far shorter than 2^32 cycles, so it cannot. Same-cycle eviction and fill never share an address in the stimulus. The only address collisions the bench creates are between a lookup and an insert, which R9 defines.

// File: rtl/vsb_pkg.sv
package vsb_pkg;

    localparam int ADDR_W        = 32;
    localparam int BLOCK_BYTES   = 128;
    localparam int OFF_W         = $clog2(BLOCK_BYTES);
    localparam int TAG_W         = ADDR_W - OFF_W;
    localparam int CNT_W         = 4;
    localparam int CNT_MAX       = (1 << CNT_W) - 1;
    localparam int ROWS_PER_BLK  = 16;
    localparam int STREAM_SLOTS  = 3;
    localparam int STAMP_W       = 32;

    typedef logic [TAG_W-1:0]   tag_t;
    typedef logic [CNT_W-1:0]   cnt_t;
    typedef logic [STAMP_W-1:0] stamp_t;

    typedef struct packed {
        logic   valid;
        tag_t   tag;
        cnt_t   cnt;
        stamp_t stamp;
    } mt_row_t;

    typedef struct packed {
        logic   valid;
        logic   dirty;
        tag_t   tag;
        cnt_t   cnt;
        stamp_t stamp;
    } slot_t;

    function automatic cnt_t cnt_bump(input cnt_t c);
        return (c == cnt_t'(CNT_MAX)) ? c : c + cnt_t'(1);
    endfunction

endpackage

// File: rtl/vsb_miss_table.sv
module vsb_miss_table
    import vsb_pkg::*;
#(
    parameter int ROWS = 16
) (
    input  logic   clk,
    input  logic   rst,
    input  stamp_t tick,
    input  logic   upd_en,
    input  tag_t   upd_tag,
    input  tag_t   qry_tag,
    output cnt_t   qry_cnt
);
    localparam int IDX_W = (ROWS > 1) ? $clog2(ROWS) : 1;

    mt_row_t tbl [ROWS];

    logic             upd_hit, has_free;
    logic [IDX_W-1:0] hit_idx, free_idx, old_idx, tgt;
    stamp_t           old_stamp;

    always_comb begin
        qry_cnt   = '0;
        upd_hit   = 1'b0;
        hit_idx   = '0;
        has_free  = 1'b0;
        free_idx  = '0;
        old_idx   = '0;
        old_stamp = '1;
        for (int i = 0; i < ROWS; i++) begin
            if (tbl[i].valid && tbl[i].tag == qry_tag) qry_cnt = tbl[i].cnt;
            if (tbl[i].valid && tbl[i].tag == upd_tag) begin
                upd_hit = 1'b1;
                hit_idx = IDX_W'(i);
            end
            if (!tbl[i].valid && !has_free) begin
                has_free = 1'b1;
                free_idx = IDX_W'(i);
            end
            if (tbl[i].valid && tbl[i].stamp < old_stamp) begin
                old_stamp = tbl[i].stamp;
                old_idx   = IDX_W'(i);
            end
        end
        tgt = upd_hit ? hit_idx : (has_free ? free_idx : old_idx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ROWS; i++) tbl[i] <= '0;
        end else if (upd_en) begin
            tbl[tgt].valid <= 1'b1;
            tbl[tgt].tag   <= upd_tag;
            tbl[tgt].cnt   <= upd_hit ? cnt_bump(tbl[tgt].cnt) : cnt_t'(1);
            tbl[tgt].stamp <= tick;
        end
    end

    always @(posedge clk) begin
        if (!rst) begin
            for (int i = 0; i < ROWS; i++) begin
                // R5
                live_count_chk: assert (!tbl[i].valid || tbl[i].cnt != '0);
            end
        end
    end

endmodule

// File: rtl/vsb_region.sv
module vsb_region
    import vsb_pkg::*;
#(
    parameter int SLOTS  = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  stamp_t            tick,
    input  logic              lk_en,
    input  tag_t              lk_tag,
    output logic              hit,
    output logic              hit_dirty,
    output logic [DATA_W-1:0] hit_data,
    input  logic              ins_en,
    input  tag_t              ins_tag,
    input  logic [DATA_W-1:0] ins_data,
    input  logic              ins_dirty,
    input  cnt_t              ins_cnt,
    output logic              wb_valid,
    output tag_t              wb_tag,
    output logic [DATA_W-1:0] wb_data
);
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    slot_t             meta  [SLOTS];
    logic [DATA_W-1:0] store [SLOTS];
    logic [SLOTS-1:0]  hit_vec, same_vec;

    for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
        assign hit_vec[g]  = lk_en && meta[g].valid && meta[g].tag == lk_tag;
        assign same_vec[g] = meta[g].valid && meta[g].tag == ins_tag;
    end

    logic             has_same, has_free, take, displace;
    logic [IDX_W-1:0] same_idx, free_idx, old_idx, tgt;
    stamp_t           old_stamp;
    cnt_t             floor_cnt;

    always_comb begin
        hit       = 1'b0;
        hit_dirty = 1'b0;
        hit_data  = '0;
        has_same  = 1'b0;
        same_idx  = '0;
        has_free  = 1'b0;
        free_idx  = '0;
        old_idx   = '0;
        old_stamp = '1;
        floor_cnt = cnt_t'(CNT_MAX);
        for (int i = 0; i < SLOTS; i++) begin
            if (hit_vec[i]) begin
                hit       = 1'b1;
                hit_dirty = meta[i].dirty;
                hit_data  = store[i];
            end
            if (same_vec[i]) begin
                has_same = 1'b1;
                same_idx = IDX_W'(i);
            end
            if (!meta[i].valid && !has_free) begin
                has_free = 1'b1;
                free_idx = IDX_W'(i);
            end
            if (meta[i].valid && meta[i].stamp < old_stamp) begin
                old_stamp = meta[i].stamp;
                old_idx   = IDX_W'(i);
            end
            if (meta[i].valid && meta[i].cnt < floor_cnt) floor_cnt = meta[i].cnt;
        end
        take     = ins_en && (has_same || has_free || ins_cnt >= floor_cnt);
        displace = take && !has_same && !has_free;
        tgt      = has_same ? same_idx : (has_free ? free_idx : old_idx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_valid <= 1'b0;
            wb_tag   <= '0;
            for (int i = 0; i < SLOTS; i++) meta[i] <= '0;
        end else begin
            wb_valid <= displace && meta[old_idx].dirty;
            wb_tag   <= meta[old_idx].tag;
            for (int i = 0; i < SLOTS; i++) begin
                if (hit_vec[i]) meta[i].valid <= 1'b0;
            end
            if (take) begin
                meta[tgt].valid <= 1'b1;
                meta[tgt].dirty <= ins_dirty || (has_same && meta[tgt].dirty);
                meta[tgt].tag   <= ins_tag;
                meta[tgt].cnt   <= ins_cnt;
                meta[tgt].stamp <= tick;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (take) store[tgt] <= ins_data;
        wb_data <= store[old_idx];
    end

    // R3
    single_hit_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    // R7
    wb_cause_chk: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> $past(ins_en && !has_same && !has_free));

endmodule

// File: rtl/victim_stream_buf.sv
module victim_stream_buf
    import vsb_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int MT_BLOCKS  = 1,
    parameter int VIC_BLOCKS = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              lk_valid,
    input  logic [1:0]        lk_core,
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic              ev_valid,
    input  logic [TAG_W-1:0]  ev_tag,
    input  logic [DATA_W-1:0] ev_data,
    input  logic              ev_dirty,
    input  logic              pf_valid,
    input  logic [TAG_W-1:0]  pf_tag,
    input  logic [DATA_W-1:0] pf_data,
    output logic              rsp_valid,
    output logic [1:0]        rsp_core,
    output logic              rsp_hit,
    output logic              rsp_dirty,
    output logic [DATA_W-1:0] rsp_data,
    output logic              wb_valid,
    output logic [TAG_W-1:0]  wb_tag,
    output logic [DATA_W-1:0] wb_data
);
    localparam int MT_ROWS = ROWS_PER_BLK * MT_BLOCKS;

    stamp_t tick;
    logic   lk_go, ev_go, pf_go;
    cnt_t   ev_cnt;

    assign lk_go = en && lk_valid;
    assign ev_go = en && ev_valid && !(lk_go && ev_tag == lk_tag);
    assign pf_go = en && pf_valid && !(lk_go && pf_tag == lk_tag);

    always_ff @(posedge clk) begin
        if (rst) tick <= '0;
        else     tick <= tick + stamp_t'(1);
    end

    vsb_miss_table #(.ROWS(MT_ROWS)) u_mt (
        .clk(clk), .rst(rst), .tick(tick),
        .upd_en(lk_go), .upd_tag(lk_tag),
        .qry_tag(ev_tag), .qry_cnt(ev_cnt)
    );

    logic              v_hit, v_dirty, v_wb;
    logic [DATA_W-1:0] v_data, v_wdata;
    tag_t              v_wtag;
    logic              s_hit, s_dirty, s_wb;
    logic [DATA_W-1:0] s_data, s_wdata;
    tag_t              s_wtag;

    vsb_region #(.SLOTS(VIC_BLOCKS), .DATA_W(DATA_W)) u_vic (
        .clk(clk), .rst(rst), .tick(tick),
        .lk_en(lk_go), .lk_tag(lk_tag),
        .hit(v_hit), .hit_dirty(v_dirty), .hit_data(v_data),
        .ins_en(ev_go), .ins_tag(ev_tag), .ins_data(ev_data),
        .ins_dirty(ev_dirty), .ins_cnt(ev_cnt),
        .wb_valid(v_wb), .wb_tag(v_wtag), .wb_data(v_wdata)
    );

    vsb_region #(.SLOTS(STREAM_SLOTS), .DATA_W(DATA_W)) u_str (
        .clk(clk), .rst(rst), .tick(tick),
        .lk_en(lk_go), .lk_tag(lk_tag),
        .hit(s_hit), .hit_dirty(s_dirty), .hit_data(s_data),
        .ins_en(pf_go), .ins_tag(pf_tag), .ins_data(pf_data),
        .ins_dirty(1'b0), .ins_cnt(cnt_t'(CNT_MAX)),
        .wb_valid(s_wb), .wb_tag(s_wtag), .wb_data(s_wdata)
    );

    assign wb_valid = v_wb || s_wb;
    assign wb_tag   = v_wb ? v_wtag  : s_wtag;
    assign wb_data  = v_wb ? v_wdata : s_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_core  <= '0;
            rsp_hit   <= 1'b0;
            rsp_dirty <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_core  <= lk_core;
            rsp_hit   <= v_hit || s_hit;
            rsp_dirty <= v_hit ? v_dirty : s_dirty;
            rsp_data  <= v_hit ? v_data  : s_data;
        end
    end

    // R2
    rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (rsp_valid == $past(lk_valid)));

    // R8
    off_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !en) |=> !rsp_hit);

endmodule

// File: tb/victim_stream_buf_tb.sv
module victim_stream_buf_tb;

    localparam int MTN = 16;
    localparam int VN  = 5;
    localparam int SN  = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b1;
    logic        lk_valid = 1'b0;
    logic [1:0]  lk_core = '0;
    logic [24:0] lk_tag = '0;
    logic        ev_valid = 1'b0;
    logic [24:0] ev_tag = '0;
    logic [31:0] ev_data = '0;
    logic        ev_dirty = 1'b0;
    logic        pf_valid = 1'b0;
    logic [24:0] pf_tag = '0;
    logic [31:0] pf_data = '0;
    logic        rsp_valid, rsp_hit, rsp_dirty, wb_valid;
    logic [1:0]  rsp_core;
    logic [31:0] rsp_data, wb_data;
    logic [24:0] wb_tag;

    always #4 clk = ~clk;

    victim_stream_buf u_dut (
        .clk(clk), .rst(rst), .en(en),
        .lk_valid(lk_valid), .lk_core(lk_core), .lk_tag(lk_tag),
        .ev_valid(ev_valid), .ev_tag(ev_tag), .ev_data(ev_data), .ev_dirty(ev_dirty),
        .pf_valid(pf_valid), .pf_tag(pf_tag), .pf_data(pf_data),
        .rsp_valid(rsp_valid), .rsp_core(rsp_core), .rsp_hit(rsp_hit),
        .rsp_dirty(rsp_dirty), .rsp_data(rsp_data),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int cyc = 0;

    bit          mt_v [MTN];
    logic [24:0] mt_t [MTN];
    int          mt_c [MTN];
    int          mt_s [MTN];
    bit          vv [VN];
    logic [24:0] vt [VN];
    logic [31:0] vd [VN];
    bit          vdr [VN];
    int          vc [VN];
    int          vs [VN];
    bit          sv [SN];
    logic [24:0] st [SN];
    logic [31:0] sd [SN];
    int          ss [SN];

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
        end
    endtask

    function automatic int mt_count(input logic [24:0] t);
        for (int i = 0; i < MTN; i++) if (mt_v[i] && mt_t[i] == t) return mt_c[i];
        return 0;
    endfunction

    task automatic step(input string rq);
        bit lkg, evg, pfg, e_rv, e_hit, e_dr, e_wb;
        logic [1:0] e_core;
        logic [31:0] e_dat, e_wd;
        logic [24:0] e_wt;
        int vi, si, m, f, l, c, mn, ls;
        lkg = en && lk_valid;
        e_rv = lk_valid; e_core = lk_core; e_hit = 0; e_dat = 0; e_dr = 0;
        e_wb = 0; e_wt = 0; e_wd = 0; vi = -1; si = -1;
        if (lkg) begin
            for (int i = 0; i < VN; i++)
                if (vv[i] && vt[i] == lk_tag) begin e_hit = 1; e_dat = vd[i]; e_dr = vdr[i]; vi = i; end
            if (!e_hit)
                for (int i = 0; i < SN; i++)
                    if (sv[i] && st[i] == lk_tag) begin e_hit = 1; e_dat = sd[i]; e_dr = 0; si = i; end
        end
        evg = en && ev_valid && !(lkg && ev_tag == lk_tag);
        pfg = en && pf_valid && !(lkg && pf_tag == lk_tag);
        if (evg) begin
            c = mt_count(ev_tag); m = -1; f = -1; mn = 99; l = -1; ls = 32'h7fffffff;
            for (int i = 0; i < VN; i++) begin
                if (vv[i] && vt[i] == ev_tag) m = i;
                if (!vv[i] && f < 0) f = i;
                if (vv[i] && vc[i] < mn) mn = vc[i];
                if (vv[i] && vs[i] < ls) begin ls = vs[i]; l = i; end
            end
            if (m >= 0) begin
                vd[m] = ev_data; vdr[m] = vdr[m] | ev_dirty; vc[m] = c; vs[m] = cyc;
            end else if (f >= 0) begin
                vv[f] = 1; vt[f] = ev_tag; vd[f] = ev_data; vdr[f] = ev_dirty; vc[f] = c; vs[f] = cyc;
            end else if (c >= mn) begin
                if (vdr[l]) begin e_wb = 1; e_wt = vt[l]; e_wd = vd[l]; end
                vt[l] = ev_tag; vd[l] = ev_data; vdr[l] = ev_dirty; vc[l] = c; vs[l] = cyc;
            end
        end
        if (pfg) begin
            m = -1; f = -1; l = -1; ls = 32'h7fffffff;
            for (int i = 0; i < SN; i++) begin
                if (sv[i] && st[i] == pf_tag) m = i;
                if (!sv[i] && f < 0) f = i;
                if (sv[i] && ss[i] < ls) begin ls = ss[i]; l = i; end
            end
            if (m < 0) m = (f >= 0) ? f : l;
            sv[m] = 1; st[m] = pf_tag; sd[m] = pf_data; ss[m] = cyc;
        end
        if (vi >= 0) vv[vi] = 0;
        if (si >= 0) sv[si] = 0;
        if (lkg) begin
            m = -1; f = -1; l = -1; ls = 32'h7fffffff;
            for (int i = 0; i < MTN; i++) begin
                if (mt_v[i] && mt_t[i] == lk_tag) m = i;
                if (!mt_v[i] && f < 0) f = i;
                if (mt_v[i] && mt_s[i] < ls) begin ls = mt_s[i]; l = i; end
            end
            if (m >= 0) begin
                if (mt_c[m] < 15) mt_c[m]++;
            end else begin
                m = (f >= 0) ? f : l;
                mt_v[m] = 1; mt_t[m] = lk_tag; mt_c[m] = 1;
            end
            mt_s[m] = cyc;
        end
        cyc++;
        @(posedge clk); #1;
        chk(rsp_valid === e_rv, rq, "rsp_valid", 64'(rsp_valid), 64'(e_rv));
        if (e_rv) begin
            chk(rsp_core === e_core, rq, "rsp_core", 64'(rsp_core), 64'(e_core));
            chk(rsp_hit === e_hit, rq, "rsp_hit", 64'(rsp_hit), 64'(e_hit));
            if (e_hit) begin
                chk(rsp_data === e_dat, rq, "rsp_data", 64'(rsp_data), 64'(e_dat));
                chk(rsp_dirty === e_dr, rq, "rsp_dirty", 64'(rsp_dirty), 64'(e_dr));
            end
        end
        chk(wb_valid === e_wb, rq, "wb_valid", 64'(wb_valid), 64'(e_wb));
        if (e_wb) begin
            chk(wb_tag === e_wt, rq, "wb_tag", 64'(wb_tag), 64'(e_wt));
            chk(wb_data === e_wd, rq, "wb_data", 64'(wb_data), 64'(e_wd));
        end
    endtask

    task automatic idle_in();
        lk_valid = 0; ev_valid = 0; pf_valid = 0;
    endtask

    task automatic lk(input string rq, input logic [24:0] t, input logic [1:0] core);
        lk_valid = 1; lk_tag = t; lk_core = core;
        step(rq); idle_in();
    endtask

    task automatic ev(input string rq, input logic [24:0] t, input logic [31:0] d, input bit dr);
        ev_valid = 1; ev_tag = t; ev_data = d; ev_dirty = dr;
        step(rq); idle_in();
    endtask

    task automatic pf(input string rq, input logic [24:0] t, input logic [31:0] d);
        pf_valid = 1; pf_tag = t; pf_data = d;
        step(rq); idle_in();
    endtask

    initial begin
        for (int i = 0; i < MTN; i++) mt_v[i] = 0;
        for (int i = 0; i < VN; i++) vv[i] = 0;
        for (int i = 0; i < SN; i++) sv[i] = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        chk(rsp_valid === 1'b0, "R1", "rsp_valid after reset", 64'(rsp_valid), 0);
        chk(wb_valid === 1'b0, "R1", "wb_valid after reset", 64'(wb_valid), 0);
        lk("R1", 25'h10, 2'd0);
        step("R2");
        // victim hit, then slot freed
        ev("R3", 25'h100, 32'hA1, 1);
        lk("R3", 25'h100, 2'd1);
        lk("R3", 25'h100, 2'd2);
        // in-place update
        ev("R11", 25'h101, 32'hB1, 0);
        ev("R11", 25'h101, 32'hB2, 1);
        lk("R11", 25'h101, 2'd3);
        // stream region
        for (int k = 0; k < 4; k++) pf("R4", 25'h200 + 25'(k), 32'hC0 + 32'(k));
        lk("R4", 25'h200, 2'd0);
        lk("R4", 25'h201, 2'd1);
        pf("R10", 25'h210, 32'hD0);
        lk("R10", 25'h210, 2'd3);
        lk("R10", 25'h202, 2'd2);
        // build miss counts 2..6, then fill victims
        for (int k = 0; k < 5; k++)
            for (int j = 0; j < k + 2; j++) lk("R5", 25'h300 + 25'(k), 2'(j));
        for (int k = 0; k < 5; k++) ev("R6", 25'h300 + 25'(k), 32'hE0 + 32'(k), 1);
        ev("R6", 25'h3F0, 32'hEF, 1);
        lk("R6", 25'h3F0, 2'd0);
        for (int j = 0; j < 17; j++) lk("R5", 25'h400, 2'd1);
        ev("R7", 25'h400, 32'hF0, 1);
        lk("R7", 25'h300, 2'd0);
        lk("R7", 25'h400, 2'd2);
        // age out the miss table
        for (int k = 0; k < 16; k++) lk("R5", 25'h500 + 25'(k), 2'd3);
        ev("R6", 25'h500, 32'h50, 0);
        ev("R5", 25'h3F0, 32'h3F, 1);
        lk("R5", 25'h3F0, 2'd0);
        ev("R7", 25'h50E, 32'h5E, 0);
        ev("R7", 25'h50D, 32'h5D, 0);
        ev("R7", 25'h50C, 32'h5C, 0);
        ev("R7", 25'h50B, 32'h5B, 0);
        ev("R7", 25'h50A, 32'h5A, 0);
        // disabled
        en = 0;
        lk("R8", 25'h50E, 2'd1);
        ev("R8", 25'h600, 32'h60, 1);
        pf("R8", 25'h601, 32'h61);
        lk("R8", 25'h50D, 2'd2);
        en = 1;
        lk("R8", 25'h50E, 2'd1);
        lk("R8", 25'h600, 2'd0);
        lk("R8", 25'h601, 2'd0);
        // same-cycle collision
        lk_valid = 1; lk_tag = 25'h700; lk_core = 2'd2;
        ev_valid = 1; ev_tag = 25'h700; ev_data = 32'h70; ev_dirty = 1;
        step("R9"); idle_in();
        lk("R9", 25'h700, 2'd2);
        lk_valid = 1; lk_tag = 25'h701; lk_core = 2'd1;
        pf_valid = 1; pf_tag = 25'h701; pf_data = 32'h71;
        step("R9"); idle_in();
        lk("R9", 25'h701, 2'd1);
        lk("R10", 25'h50D, 2'd3);
        step("R2");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog act=running exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule